// File: doc/BRIEF.md
# Interrupt Pin Capture and Dispatch

This block is the request-capture and dispatch core of an I/O interrupt controller. It watches a vector of interrupt input pins and keeps one pending flag per pin. The pin's configured trigger mode decides how the flag behaves: edge mode latches a rising input until it is delivered, and level mode follows the input. A service pass then walks the pins and sends one delivery message for every pending, unmasked pin. The message is built from that pin's redirection settings, which arrive already decoded on flattened input buses.

A rise on any pin or a pulse on the entry-write input starts a pass. The pass checks one pin per clock, starting from pin 0 and going upward. Each message waits on a valid/ready port until it is taken. When a pin is configured for external-interrupt delivery, the engine first asks a legacy controller for the vector over a request/acknowledge handshake. Input pin 0 has no flag of its own: its requests are folded onto pin 2 and follow pin 2's settings.

Top module: `irq_pin_dispatch`

## Requirements
- R1: A rise on input pin 0 raises the pending flag of pin 2, so the resulting message carries pin 2's settings.
- R2: For a pin whose trigger bit is 1 (level), a rise sets its pending flag and a fall clears it, so that a later pass sends nothing for it.
- R3: For a pin whose trigger bit is 0 (edge), a fall of the input leaves the pending flag unchanged.
- R4: Any pin rise or an entry-write pulse starts a pass when the engine is idle. A start that arrives during a pass causes exactly one further full pass after the current one.
- R5: A pass examines pins from index 0 upward, one per clock. It sends a message for each pin that is pending and has its mask bit clear. A masked pending pin is skipped and stays pending.
- R6: When its message is accepted, an edge pin's pending flag is cleared. A level pin's flag stays set, so every later pass sends it again.
- R7: When a pin's 3-bit delivery mode is 7, the engine holds `lg_req` high until `lg_ack` is seen and uses `lg_vec` as the vector. In every other mode the vector comes from the pin's entry. `lg_req` and `dv_valid` are never high together.
- R8: Each message carries the pin's destination, destination mode, delivery mode, vector, polarity and trigger bit. All of these stay stable while `dv_valid` is high and `dv_ready` is low.
- R9: After reset, `dv_valid` and `lg_req` are low and no pin is pending.
- R10: When an edge pin's message is accepted in the same clock as a new rise on that pin, the rise wins and the pin stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NPINS | Interrupt input levels |
| ent_mask | input | NPINS | Per-pin mask bit (1 = masked) |
| ent_trig | input | NPINS | Per-pin trigger bit (1 = level, 0 = edge) |
| ent_dstm | input | NPINS | Per-pin destination mode bit |
| ent_pol | input | NPINS | Per-pin polarity bit |
| ent_dm | input | 3*NPINS | Per-pin delivery mode, pin i at bits 3i+2:3i |
| ent_vec | input | VEC_W*NPINS | Per-pin vector, pin i at bits VEC_W*i upward |
| ent_dest | input | DEST_W*NPINS | Per-pin destination, pin i at bits DEST_W*i upward |
| ent_wr | input | 1 | Pulse: an entry was rewritten, start a pass |
| lg_req | output | 1 | Vector request to the legacy controller |
| lg_ack | input | 1 | Legacy controller acknowledge, vector valid |
| lg_vec | input | VEC_W | Vector supplied by the legacy controller |
| dv_valid | output | 1 | Delivery message valid |
| dv_ready | input | 1 | Delivery message accepted |
| dv_dest | output | DEST_W | Message destination |
| dv_dstm | output | 1 | Message destination mode |
| dv_dm | output | 3 | Message delivery mode |
| dv_vec | output | VEC_W | Message vector |
| dv_pol | output | 1 | Message polarity |
| dv_trig | output | 1 | Message trigger bit |

## Verification
Two functions can act on the same pending flag in one clock: the clear that follows acceptance of an edge pin's message, and a fresh rise of that pin's input. The bench first stalls the delivery port while a pin's message is waiting, then drops and re-raises that pin so that the new rise reaches the clock edge together with `dv_ready`. It expects a second message for the pin. A design that lets the clear win sends only one, because its extra pass finds the flag already cleared. A behavioural model, compared on every clock, also covers the overlap of a mid-pass start request with the end of a pass.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_FETCH = 2'd2,
        ST_SEND  = 2'd3
    } scan_st_e;

    localparam logic [2:0] DM_EXTINT = 3'd7;
    localparam logic       TRIG_EDGE = 1'b0;

endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
    parameter int NPINS     = 24,
    parameter int REMAP_SRC = 0,
    parameter int REMAP_DST = 2,
    localparam int IDX_W    = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] trig_lvl,
    input  logic             dclr_en,
    input  logic [IDX_W-1:0] dclr_idx,
    output logic [NPINS-1:0] pend,
    output logic             start
);

    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] pend;
    } trk_t;

    trk_t trk_d, trk_q;

    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] set_oh  [NPINS];
    logic [NPINS-1:0] lclr_oh [NPINS];

    // each raw pin drives one target flag; the remapped source drives another
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        localparam int TGT = (i == REMAP_SRC) ? REMAP_DST : i;
        localparam logic [NPINS-1:0] TBIT = NPINS'(1) << TGT;
        logic fall;
        assign rise[i]    = pin_lvl[i] & ~trk_q.prev[i];
        assign fall       = ~pin_lvl[i] & trk_q.prev[i];
        assign set_oh[i]  = rise[i] ? TBIT : '0;
        assign lclr_oh[i] = (fall && trig_lvl[TGT]) ? TBIT : '0;
    end

    always_comb begin
        logic [NPINS-1:0] set_v;
        logic [NPINS-1:0] clr_v;
        set_v = '0;
        clr_v = '0;
        for (int i = 0; i < NPINS; i++) begin
            set_v = set_v | set_oh[i];
            clr_v = clr_v | lclr_oh[i];
        end
        if (dclr_en) begin
            clr_v = clr_v | (NPINS'(1) << dclr_idx);
        end
        trk_d.prev = pin_lvl;
        // a new rise wins over any clear landing in the same cycle
        trk_d.pend = (trk_q.pend & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign pend  = trk_q.pend;
    assign start = |rise;

endmodule

// File: rtl/irq_entry_sel.sv
module irq_entry_sel #(
    parameter int NPINS  = 24,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic [NPINS-1:0]        ent_mask,
    input  logic [NPINS-1:0]        ent_trig,
    input  logic [NPINS-1:0]        ent_dstm,
    input  logic [NPINS-1:0]        ent_pol,
    input  logic [3*NPINS-1:0]      ent_dm,
    input  logic [VEC_W*NPINS-1:0]  ent_vec,
    input  logic [DEST_W*NPINS-1:0] ent_dest,
    output logic                    sel_mask,
    output logic                    sel_trig,
    output logic                    sel_dstm,
    output logic                    sel_pol,
    output logic [2:0]              sel_dm,
    output logic [VEC_W-1:0]        sel_vec,
    output logic [DEST_W-1:0]       sel_dest
);

    always_comb begin
        sel_mask = ent_mask[idx];
        sel_trig = ent_trig[idx];
        sel_dstm = ent_dstm[idx];
        sel_pol  = ent_pol[idx];
        sel_dm   = ent_dm[int'(idx)*3 +: 3];
        sel_vec  = ent_vec[int'(idx)*VEC_W +: VEC_W];
        sel_dest = ent_dest[int'(idx)*DEST_W +: DEST_W];
    end

endmodule

// File: rtl/irq_scan_engine.sv
module irq_scan_engine
    import irq_disp_pkg::*;
#(
    parameter int NPINS  = 24,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NPINS-1:0]  pend,
    input  logic              sel_mask,
    input  logic              sel_trig,
    input  logic              sel_dstm,
    input  logic              sel_pol,
    input  logic [2:0]        sel_dm,
    input  logic [VEC_W-1:0]  sel_vec,
    input  logic [DEST_W-1:0] sel_dest,
    input  logic              dv_ready,
    input  logic              lg_ack,
    input  logic [VEC_W-1:0]  lg_vec,
    output logic [IDX_W-1:0]  idx,
    output logic              dclr_en,
    output logic              lg_req,
    output logic              dv_valid,
    output logic [DEST_W-1:0] dv_dest,
    output logic              dv_dstm,
    output logic [2:0]        dv_dm,
    output logic [VEC_W-1:0]  dv_vec,
    output logic              dv_pol,
    output logic              dv_trig
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NPINS - 1);

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              dstm;
        logic [2:0]        dm;
        logic [VEC_W-1:0]  vec;
        logic              pol;
        logic              trig;
    } msg_t;

    typedef struct packed {
        scan_st_e         st;
        logic [IDX_W-1:0] idx;
        logic             again;
        msg_t             msg;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        logic again_n;
        logic finish;
        eng_d   = eng_q;
        dclr_en = 1'b0;
        finish  = 1'b0;
        again_n = eng_q.again | (start && eng_q.st != ST_IDLE);
        case (eng_q.st)
            ST_IDLE: begin
                if (start) begin
                    eng_d.st    = ST_SCAN;
                    eng_d.idx   = '0;
                    eng_d.again = 1'b0;
                end
            end
            ST_SCAN: begin
                eng_d.again = again_n;
                if (pend[eng_q.idx] && !sel_mask) begin
                    eng_d.msg.dest = sel_dest;
                    eng_d.msg.dstm = sel_dstm;
                    eng_d.msg.dm   = sel_dm;
                    eng_d.msg.vec  = sel_vec;
                    eng_d.msg.pol  = sel_pol;
                    eng_d.msg.trig = sel_trig;
                    eng_d.st = (sel_dm == DM_EXTINT) ? ST_FETCH : ST_SEND;
                end else if (eng_q.idx == LAST) begin
                    finish = 1'b1;
                end else begin
                    eng_d.idx = eng_q.idx + IDX_W'(1);
                end
            end
            ST_FETCH: begin
                eng_d.again = again_n;
                if (lg_ack) begin
                    eng_d.msg.vec = lg_vec;
                    eng_d.st      = ST_SEND;
                end
            end
            default: begin
                eng_d.again = again_n;
                if (dv_ready) begin
                    dclr_en = (eng_q.msg.trig == TRIG_EDGE);
                    if (eng_q.idx == LAST) begin
                        finish = 1'b1;
                    end else begin
                        eng_d.idx = eng_q.idx + IDX_W'(1);
                        eng_d.st  = ST_SCAN;
                    end
                end
            end
        endcase
        if (finish) begin
            eng_d.again = 1'b0;
            eng_d.idx   = '0;
            eng_d.st    = again_n ? ST_SCAN : ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, idx: '0, again: 1'b0, msg: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign idx      = eng_q.idx;
    assign lg_req   = (eng_q.st == ST_FETCH);
    assign dv_valid = (eng_q.st == ST_SEND);
    assign dv_dest  = eng_q.msg.dest;
    assign dv_dstm  = eng_q.msg.dstm;
    assign dv_dm    = eng_q.msg.dm;
    assign dv_vec   = eng_q.msg.vec;
    assign dv_pol   = eng_q.msg.pol;
    assign dv_trig  = eng_q.msg.trig;

endmodule

// File: rtl/irq_pin_dispatch.sv
module irq_pin_dispatch #(
    parameter int NPINS  = 24,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        pin_lvl,
    input  logic [NPINS-1:0]        ent_mask,
    input  logic [NPINS-1:0]        ent_trig,
    input  logic [NPINS-1:0]        ent_dstm,
    input  logic [NPINS-1:0]        ent_pol,
    input  logic [3*NPINS-1:0]      ent_dm,
    input  logic [VEC_W*NPINS-1:0]  ent_vec,
    input  logic [DEST_W*NPINS-1:0] ent_dest,
    input  logic                    ent_wr,
    output logic                    lg_req,
    input  logic                    lg_ack,
    input  logic [VEC_W-1:0]        lg_vec,
    output logic                    dv_valid,
    input  logic                    dv_ready,
    output logic [DEST_W-1:0]       dv_dest,
    output logic                    dv_dstm,
    output logic [2:0]              dv_dm,
    output logic [VEC_W-1:0]        dv_vec,
    output logic                    dv_pol,
    output logic                    dv_trig
);

    localparam int IDX_W = $clog2(NPINS);

    logic [NPINS-1:0]  pend;
    logic              pin_start;
    logic [IDX_W-1:0]  idx;
    logic              dclr_en;
    logic              sel_mask, sel_trig, sel_dstm, sel_pol;
    logic [2:0]        sel_dm;
    logic [VEC_W-1:0]  sel_vec;
    logic [DEST_W-1:0] sel_dest;

    irq_pend_track #(.NPINS(NPINS), .REMAP_SRC(0), .REMAP_DST(2)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_lvl  (pin_lvl),
        .trig_lvl (ent_trig),
        .dclr_en  (dclr_en),
        .dclr_idx (idx),
        .pend     (pend),
        .start    (pin_start)
    );

    irq_entry_sel #(.NPINS(NPINS), .VEC_W(VEC_W), .DEST_W(DEST_W)) u_sel (
        .idx      (idx),
        .ent_mask (ent_mask),
        .ent_trig (ent_trig),
        .ent_dstm (ent_dstm),
        .ent_pol  (ent_pol),
        .ent_dm   (ent_dm),
        .ent_vec  (ent_vec),
        .ent_dest (ent_dest),
        .sel_mask (sel_mask),
        .sel_trig (sel_trig),
        .sel_dstm (sel_dstm),
        .sel_pol  (sel_pol),
        .sel_dm   (sel_dm),
        .sel_vec  (sel_vec),
        .sel_dest (sel_dest)
    );

    irq_scan_engine #(.NPINS(NPINS), .VEC_W(VEC_W), .DEST_W(DEST_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (pin_start | ent_wr),
        .pend     (pend),
        .sel_mask (sel_mask),
        .sel_trig (sel_trig),
        .sel_dstm (sel_dstm),
        .sel_pol  (sel_pol),
        .sel_dm   (sel_dm),
        .sel_vec  (sel_vec),
        .sel_dest (sel_dest),
        .dv_ready (dv_ready),
        .lg_ack   (lg_ack),
        .lg_vec   (lg_vec),
        .idx      (idx),
        .dclr_en  (dclr_en),
        .lg_req   (lg_req),
        .dv_valid (dv_valid),
        .dv_dest  (dv_dest),
        .dv_dstm  (dv_dstm),
        .dv_dm    (dv_dm),
        .dv_vec   (dv_vec),
        .dv_pol   (dv_pol),
        .dv_trig  (dv_trig)
    );

endmodule

// File: rtl/irq_pin_dispatch_chk.sv
module irq_pin_dispatch_chk #(
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lg_req,
    input logic              lg_ack,
    input logic [VEC_W-1:0]  lg_vec,
    input logic              dv_valid,
    input logic              dv_ready,
    input logic [DEST_W-1:0] dv_dest,
    input logic              dv_dstm,
    input logic [2:0]        dv_dm,
    input logic [VEC_W-1:0]  dv_vec,
    input logic              dv_pol,
    input logic              dv_trig
);

    // R8: a stalled message keeps every field
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        dv_valid && !dv_ready |=> dv_valid && $stable(dv_dest) && $stable(dv_dstm)
            && $stable(dv_dm) && $stable(dv_vec) && $stable(dv_pol) && $stable(dv_trig));

    // R7: fetch and delivery never overlap
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        dv_valid |-> !lg_req);

    // R7: request held until acknowledged
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lg_req && !lg_ack |=> lg_req);

    // R7: acknowledged legacy vector becomes the message vector
    a_r7_legacy_vec: assert property (@(posedge clk) disable iff (!rst_n)
        lg_req && lg_ack |=> dv_valid && dv_vec == $past(lg_vec) && dv_dm == 3'd7);

    // R5: after acceptance the pass moves on to the next pin
    a_r5_step_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        dv_valid && dv_ready |=> !dv_valid && !lg_req);

endmodule

bind irq_pin_dispatch irq_pin_dispatch_chk #(.VEC_W(VEC_W), .DEST_W(DEST_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lg_req   (lg_req),
    .lg_ack   (lg_ack),
    .lg_vec   (lg_vec),
    .dv_valid (dv_valid),
    .dv_ready (dv_ready),
    .dv_dest  (dv_dest),
    .dv_dstm  (dv_dstm),
    .dv_dm    (dv_dm),
    .dv_vec   (dv_vec),
    .dv_pol   (dv_pol),
    .dv_trig  (dv_trig)
);

// File: tb/irq_pin_dispatch_test.sv
module irq_pin_dispatch_test;

    localparam int NP = 24;
    localparam int VW = 8;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic [NP-1:0]   pin_lvl = '0;
    logic [NP-1:0]   cfg_mask, cfg_trig, cfg_dstm, cfg_pol;
    logic [3*NP-1:0] cfg_dm;
    logic [VW*NP-1:0] cfg_vec;
    logic [DW*NP-1:0] cfg_dest;
    logic            ent_wr = 1'b0;
    logic            lg_ack = 1'b0;
    logic [VW-1:0]   lg_vec = 8'h99;
    logic            dv_ready = 1'b1;
    logic            lg_req, dv_valid, dv_dstm, dv_pol, dv_trig;
    logic [DW-1:0]   dv_dest;
    logic [2:0]      dv_dm;
    logic [VW-1:0]   dv_vec;

    irq_pin_dispatch #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .ent_mask(cfg_mask),
        .ent_trig(cfg_trig), .ent_dstm(cfg_dstm), .ent_pol(cfg_pol), .ent_dm(cfg_dm),
        .ent_vec(cfg_vec), .ent_dest(cfg_dest), .ent_wr(ent_wr), .lg_req(lg_req),
        .lg_ack(lg_ack), .lg_vec(lg_vec), .dv_valid(dv_valid), .dv_ready(dv_ready),
        .dv_dest(dv_dest), .dv_dstm(dv_dstm), .dv_dm(dv_dm), .dv_vec(dv_vec),
        .dv_pol(dv_pol), .dv_trig(dv_trig)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int lat = 0;
    int hs_vec[$];
    int hs_dm[$];

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_st = 0;     // 0 idle, 1 scanning, 2 waiting legacy vector, 3 offering message
    int  m_idx = 0;
    bit  m_again = 0;
    bit  m_pend[NP];
    bit  m_prev[NP];
    int  m_vec = 0, m_dest = 0, m_dm = 0;
    bit  m_dstm = 0, m_pol = 0, m_trig = 0;
    bit  s_set[NP];
    bit  s_lclr[NP];

    always @(posedge clk) begin
        int  tgt;
        int  dclr;
        bit  strt;
        bit  agn;
        bit  fin;
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_again = 0;
            for (int i = 0; i < NP; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
        end else begin
            strt = ent_wr;
            for (int i = 0; i < NP; i++) begin s_set[i] = 0; s_lclr[i] = 0; end
            for (int i = 0; i < NP; i++) begin
                tgt = (i == 0) ? 2 : i;
                if (pin_lvl[i] && !m_prev[i]) begin s_set[tgt] = 1; strt = 1; end
                if (!pin_lvl[i] && m_prev[i] && cfg_trig[tgt]) s_lclr[tgt] = 1;
            end
            dclr = -1;
            fin  = 0;
            agn  = m_again || (strt && m_st != 0);
            if (m_st == 0) begin
                if (strt) begin m_st = 1; m_idx = 0; m_again = 0; end
            end else if (m_st == 1) begin
                m_again = agn;
                if (m_pend[m_idx] && !cfg_mask[m_idx]) begin
                    m_vec  = cfg_vec[m_idx*VW +: VW];
                    m_dest = cfg_dest[m_idx*DW +: DW];
                    m_dm   = cfg_dm[m_idx*3 +: 3];
                    m_dstm = cfg_dstm[m_idx];
                    m_pol  = cfg_pol[m_idx];
                    m_trig = cfg_trig[m_idx];
                    m_st   = (m_dm == 7) ? 2 : 3;
                end else if (m_idx == NP - 1) fin = 1;
                else m_idx++;
            end else if (m_st == 2) begin
                m_again = agn;
                if (lg_ack) begin m_vec = lg_vec; m_st = 3; end
            end else begin
                m_again = agn;
                if (dv_ready) begin
                    if (!m_trig) dclr = m_idx;
                    if (m_idx == NP - 1) fin = 1;
                    else begin m_idx++; m_st = 1; end
                end
            end
            if (fin) begin
                m_again = 0; m_idx = 0;
                m_st = agn ? 1 : 0;
            end
            for (int i = 0; i < NP; i++) begin
                if (s_lclr[i] || i == dclr) m_pend[i] = 0;
                if (s_set[i]) m_pend[i] = 1;
                m_prev[i] = pin_lvl[i];
            end
        end
    end

    // per-cycle comparison and acceptance log, half a period after the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(dv_valid === (m_st == 3), "R5 dv_valid vs model", dv_valid, m_st == 3);
            chk(lg_req === (m_st == 2), "R7 lg_req vs model", lg_req, m_st == 2);
            if (m_st == 3) begin
                chk({dv_dest, dv_dstm, dv_dm, dv_vec, dv_pol, dv_trig} ===
                    {DW'(m_dest), m_dstm, 3'(m_dm), VW'(m_vec), m_pol, m_trig},
                    "R8 message fields vs model",
                    {dv_dest, dv_dstm, dv_dm, dv_vec, dv_pol, dv_trig},
                    {DW'(m_dest), m_dstm, 3'(m_dm), VW'(m_vec), m_pol, m_trig});
            end
            if (dv_valid && dv_ready) begin
                hs_vec.push_back(int'(dv_vec));
                hs_dm.push_back(int'(dv_dm));
            end
        end
    end

    // delivery-port ready pattern
    always @(posedge clk) begin
        #2;
        cyc++;
        case (rdy_mode)
            0: dv_ready = 1'b1;
            1: dv_ready = (cyc % 3 != 0);
            default: dv_ready = 1'b0;
        endcase
    end

    // legacy controller responder: acknowledges after three cycles of request
    always @(posedge clk) begin
        #3;
        if (lg_req && !lg_ack) begin
            lat++;
            if (lat >= 3) lg_ack = 1'b1;
        end else begin
            lg_ack = 1'b0;
            lat = 0;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #4; end
    endtask

    task automatic pulse_wr();
        ent_wr = 1'b1; step(1); ent_wr = 1'b0;
    endtask

    task automatic clear_log();
        hs_vec.delete(); hs_dm.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) begin
            cfg_vec[i*VW +: VW]  = VW'(32 + i);
            cfg_dest[i*DW +: DW] = DW'(i);
            cfg_dm[i*3 +: 3]     = 3'd0;
            cfg_mask[i] = 1'b1;
            cfg_trig[i] = 1'b0;
            cfg_dstm[i] = i[0];
            cfg_pol[i]  = i[1];
        end
        // R9: reset state
        step(3);
        chk(dv_valid == 1'b0, "R9 dv_valid in reset", dv_valid, 0);
        chk(lg_req == 1'b0, "R9 lg_req in reset", lg_req, 0);
        rst_n = 1'b1;
        step(2);
        cfg_mask = '0;
        pulse_wr();
        step(40);
        chk(hs_vec.size() == 0, "R9 nothing pending after reset", hs_vec.size(), 0);
        cfg_mask = '1;

        // R1: pin 0 request lands on pin 2
        clear_log();
        cfg_mask[2] = 1'b0;
        pin_lvl[0] = 1'b1;
        step(40);
        chk(hs_vec.size() == 1, "R1 one message from pin 0", hs_vec.size(), 1);
        if (hs_vec.size() > 0) chk(hs_vec[0] == 32'h22, "R1 pin 2 vector", hs_vec[0], 32'h22);
        pin_lvl[0] = 1'b0;
        step(2);

        // R5: ascending order regardless of rise pattern
        clear_log();
        cfg_mask[3] = 1'b0; cfg_mask[7] = 1'b0; cfg_mask[12] = 1'b0;
        pin_lvl[12] = 1'b1; pin_lvl[3] = 1'b1; pin_lvl[7] = 1'b1;
        step(40);
        chk(hs_vec.size() == 3, "R5 three messages", hs_vec.size(), 3);
        if (hs_vec.size() == 3) begin
            chk(hs_vec[0] == 32'h23, "R5 first pin 3", hs_vec[0], 32'h23);
            chk(hs_vec[1] == 32'h27, "R5 second pin 7", hs_vec[1], 32'h27);
            chk(hs_vec[2] == 32'h2c, "R5 third pin 12", hs_vec[2], 32'h2c);
        end
        pin_lvl[12] = 1'b0; pin_lvl[3] = 1'b0; pin_lvl[7] = 1'b0;
        step(2);

        // R5 masked stays pending, R3 edge fall ignored
        clear_log();
        pin_lvl[5] = 1'b1;
        step(40);
        chk(hs_vec.size() == 0, "R5 masked pin not sent", hs_vec.size(), 0);
        pin_lvl[5] = 1'b0;
        step(3);
        cfg_mask[5] = 1'b0;
        pulse_wr();
        step(40);
        chk(hs_vec.size() == 1, "R3 edge pin still pending after fall", hs_vec.size(), 1);
        if (hs_vec.size() > 0) chk(hs_vec[0] == 32'h25, "R3 pin 5 vector", hs_vec[0], 32'h25);

        // R2 / R6: level pin behaviour
        clear_log();
        cfg_trig[9] = 1'b1; cfg_mask[9] = 1'b0;
        pin_lvl[9] = 1'b1;
        step(40);
        chk(hs_vec.size() == 1, "R2 level rise sends", hs_vec.size(), 1);
        clear_log();
        pulse_wr();
        step(40);
        chk(hs_vec.size() == 1, "R6 level stays pending, edge pins cleared", hs_vec.size(), 1);
        clear_log();
        pin_lvl[9] = 1'b0;
        step(2);
        pulse_wr();
        step(40);
        chk(hs_vec.size() == 0, "R2 level fall clears", hs_vec.size(), 0);

        // R7: legacy vector fetch with a stuttering ready
        clear_log();
        cfg_dm[4*3 +: 3] = 3'd7; cfg_mask[4] = 1'b0;
        rdy_mode = 1;
        pin_lvl[4] = 1'b1;
        step(60);
        chk(hs_vec.size() == 1, "R7 one legacy message", hs_vec.size(), 1);
        if (hs_vec.size() > 0) begin
            chk(hs_vec[0] == 32'h99, "R7 legacy vector used", hs_vec[0], 32'h99);
            chk(hs_dm[0] == 7, "R7 delivery mode 7 carried", hs_dm[0], 7);
        end
        rdy_mode = 0;
        pin_lvl[4] = 1'b0;
        step(3);

        // R4: request during a pass gives one more full pass
        clear_log();
        cfg_trig[1] = 1'b1; cfg_mask[1] = 1'b0;
        pin_lvl[1] = 1'b1;
        step(8);
        pulse_wr();
        step(70);
        chk(hs_vec.size() == 2, "R4 extra pass after mid-pass request", hs_vec.size(), 2);
        pin_lvl[1] = 1'b0;
        step(2);
        cfg_mask[1] = 1'b1;

        // R10: new rise coincides with acceptance clear
        clear_log();
        cfg_mask[6] = 1'b0;
        rdy_mode = 2;
        step(1);
        pin_lvl[6] = 1'b1;
        step(10);
        pin_lvl[6] = 1'b0;
        step(2);
        rdy_mode = 0;
        step(1);
        pin_lvl[6] = 1'b1;
        step(60);
        chk(hs_vec.size() == 2, "R10 rise wins over acceptance clear", hs_vec.size(), 2);
        pin_lvl[6] = 1'b0;
        step(3);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule